// File: doc/BRIEF.md
# I2C Byte-Command Master Engine

This block is the bus-side engine of an I2C master with 7-bit addressing. It executes one command at a time. A command is a 5-bit word whose bits request a START condition, a byte transmit, a byte receive, a not-acknowledge for the received byte, and a STOP condition. Several bits may be combined in one command. The engine produces SCL from two separately programmed phase counts. It drives both lines open-drain, so an output of 1 means "pull the line low". It shifts bytes MSB first and checks the acknowledge slot. While it sends a 1 it watches SDA, so that it can give up the bus to another master.

The controlling logic loads a transmit byte and pulses a command. It then waits for the completion pulse, which comes exactly once per command. Status events arrive as single-cycle pulses: START generated, STOP generated, byte sent, byte received, acknowledge error and arbitration lost. A busy level follows the bus from any START to the next STOP.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both line drivers are released (`scl_oe`=0, `sda_oe`=0), `busy` is 0 and no event pulse is high.
- R2: Each SCL high phase lasts 2·(`scl_hi_div`+1) clocks and each SCL low phase inside a byte lasts 2·(`scl_lo_div`+1) clocks.
- R3: Command bit positions are stop=bit0, write=bit1, read=bit2, start=bit3, no-ack=bit4. A command with start and write set produces a START condition and one `ev_start` pulse. It then sends `tx_byte` MSB first, releases SDA for the acknowledge slot and pulses `ev_send`.
- R4: If the acknowledge bit sampled after a transmitted byte is high (not acknowledged), `ev_ackerr` pulses in the same cycle as `ev_send`. If the bit is low, `ev_ackerr` does not pulse.
- R5: A read command without no-ack receives 8 bits MSB first into `rx_byte`, pulls SDA low in the acknowledge slot and pulses `ev_recv`.
- R6: A read command with no-ack set leaves SDA released in the acknowledge slot.
- R7: The stop bit produces a STOP condition (SDA rising while SCL is high) and one `ev_end` pulse. Both lines are released when the command ends.
- R8: `ev_over` pulses exactly once per accepted command. A command with none of start, write, read or stop set gives `ev_over` in the cycle after it is accepted.
- R9: If SDA is read low while the engine sends a 1 bit of a transmitted byte, `ev_arblost` and `ev_over` pulse together, no `ev_send` follows, and both lines are released.
- R10: `busy` becomes 1 after a START condition is seen on the lines and returns to 0 after a STOP condition.
- R11: A `cmd_valid` pulse that arrives while a command is running is ignored.
- R12: SDA changes while SCL is high only to form the commanded START and STOP conditions, so no other START or STOP appears on the bus.
- R13: After a byte command without stop, SCL is held low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe, taken only when the engine is idle |
| cmd | input | 5 | Command bits: no-ack, start, read, write, stop (bit 4 down to bit 0) |
| tx_byte | input | 8 | Byte to transmit, sampled with the command |
| scl_hi_div | input | 16 | SCL high phase count |
| scl_lo_div | input | 16 | SCL low phase count |
| scl_in | input | 1 | SCL line level, synchronous to clk |
| sda_in | input | 1 | SDA line level, synchronous to clk |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_byte | output | 8 | Last received byte, valid from `ev_recv` to the next command |
| busy | output | 1 | Bus occupied between START and STOP |
| ev_start | output | 1 | START generated pulse |
| ev_end | output | 1 | STOP generated pulse |
| ev_send | output | 1 | Byte transmitted pulse |
| ev_recv | output | 1 | Byte received pulse |
| ev_ackerr | output | 1 | Transmitted byte not acknowledged pulse |
| ev_arblost | output | 1 | Arbitration lost pulse |
| ev_over | output | 1 | Command complete pulse |

## Verification
An empty command is accepted on one edge, and `ev_over` must be high at the very next sample point. The bench measures this latency to the cycle. For bus commands, `ev_over` is registered on the same edge that ends the final half-phase. The bench waits for that pulse with a bounded loop and then waits one further cycle, so that its bus model has seen the last SCL edge. Only then does it compare event counts, received bytes and line states. SCL timing is measured as run lengths between line edges, sampled on the falling clock edge. Each run is therefore a whole number of cycles, which is compared with 2·(count+1).

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int CMD_W    = 5;
  localparam int CB_STOP  = 0;
  localparam int CB_WRITE = 1;
  localparam int CB_READ  = 2;
  localparam int CB_START = 3;
  localparam int CB_NOACK = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BYTE  = 2'd2,
    ST_STOP  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/i2c_eng_phase_div.sv
module i2c_eng_phase_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             scl_high,
  input  logic [CNT_W-1:0] hi_lim,
  input  logic [CNT_W-1:0] lo_lim,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_n, lim;

  assign lim  = scl_high ? hi_lim : lo_lim;
  assign tick = run && (cnt_q == lim);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R2: half-phase counter advances by one per cycle until its limit
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/i2c_eng_shreg.sv
module i2c_eng_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (load)       q_n = din;
    else if (shift) q_n = {q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/i2c_eng_busmon.sv
module i2c_eng_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_d, sda_d, busy_n;
  logic saw_start, saw_stop;

  assign saw_start = scl_in && scl_d && sda_d && !sda_in;
  assign saw_stop  = scl_in && scl_d && !sda_d && sda_in;

  always_comb begin
    busy_n = busy;
    if (saw_start)     busy_n = 1'b1;
    else if (saw_stop) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      busy  <= busy_n;
    end
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  scl_hi_div,
  input  logic [DIV_W-1:0]  scl_lo_div,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              ev_start,
  output logic              ev_end,
  output logic              ev_send,
  output logic              ev_recv,
  output logic              ev_ackerr,
  output logic              ev_arblost,
  output logic              ev_over
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(BYTE_W);

  eng_state_e        state_q, state_n;
  logic [1:0]        step_q, step_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic              scl_q, scl_n, sda_q, sda_n, ack_q, ack_n;
  logic              tick, sh_load, sh_shift, is_wr;
  logic [BYTE_W-1:0] sh_q;
  logic e_start_n, e_end_n, e_send_n, e_recv_n, e_ackerr_n, e_arb_n, e_over_n;

  assign is_wr = cmd_q[CB_WRITE];

  i2c_eng_phase_div #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE), .scl_high(scl_q),
    .hi_lim(scl_hi_div), .lo_lim(scl_lo_div), .tick(tick));

  i2c_eng_shreg #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(tx_byte),
    .shift(sh_shift), .bit_in(sda_in), .q(sh_q));

  i2c_eng_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(busy));

  always_comb begin
    state_n = state_q; step_n = step_q; bit_n = bit_q; cmd_n = cmd_q;
    scl_n = scl_q; sda_n = sda_q; ack_n = ack_q;
    sh_load = 1'b0; sh_shift = 1'b0;
    e_start_n = 1'b0; e_end_n = 1'b0; e_send_n = 1'b0; e_recv_n = 1'b0;
    e_ackerr_n = 1'b0; e_arb_n = 1'b0; e_over_n = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          cmd_n   = cmd;
          sh_load = 1'b1;
          if (cmd[CB_START]) begin
            state_n = ST_START;
            sda_n   = 1'b1;
            if (!scl_q) begin step_n = 2'd0; scl_n = 1'b0; end
            else        begin step_n = 2'd1; scl_n = 1'b1; end
          end else if (cmd[CB_WRITE] || cmd[CB_READ]) begin
            state_n = ST_BYTE; step_n = 2'd0; bit_n = '0; scl_n = 1'b0;
            sda_n   = cmd[CB_WRITE] ? tx_byte[BYTE_W-1] : 1'b1;
          end else if (cmd[CB_STOP]) begin
            state_n = ST_STOP; step_n = 2'd0; scl_n = 1'b0; sda_n = 1'b0;
          end else begin
            e_over_n = 1'b1;
          end
        end
      end
      ST_START: begin
        if (tick) begin
          case (step_q)
            2'd0: begin step_n = 2'd1; scl_n = 1'b1; end
            2'd1: begin step_n = 2'd2; sda_n = 1'b0; e_start_n = 1'b1; end
            2'd2: step_n = 2'd3;
            default: begin
              scl_n = 1'b0;
              if (cmd_q[CB_WRITE] || cmd_q[CB_READ]) begin
                state_n = ST_BYTE; step_n = 2'd0; bit_n = '0;
                sda_n   = is_wr ? sh_q[BYTE_W-1] : 1'b1;
              end else if (cmd_q[CB_STOP]) begin
                state_n = ST_STOP; step_n = 2'd0; sda_n = 1'b0;
              end else begin
                state_n = ST_IDLE; e_over_n = 1'b1;
              end
            end
          endcase
        end
      end
      ST_BYTE: begin
        if (tick) begin
          case (step_q)
            2'd0: step_n = 2'd1;
            2'd1: begin step_n = 2'd2; scl_n = 1'b1; end
            2'd2: begin
              step_n = 2'd3;
              if (bit_q != ACK_SLOT) begin
                if (is_wr && sda_q && !sda_in) begin
                  state_n = ST_IDLE; scl_n = 1'b1; sda_n = 1'b1;
                  e_arb_n = 1'b1; e_over_n = 1'b1;
                end else begin
                  sh_shift = 1'b1;
                end
              end else begin
                ack_n = sda_in;
              end
            end
            default: begin
              scl_n = 1'b0;
              if (bit_q != ACK_SLOT) begin
                bit_n  = bit_q + 1'b1;
                step_n = 2'd0;
                if (bit_q == LAST_DATA) sda_n = is_wr ? 1'b1 : cmd_q[CB_NOACK];
                else                    sda_n = is_wr ? sh_q[BYTE_W-1] : 1'b1;
              end else begin
                if (is_wr) begin e_send_n = 1'b1; e_ackerr_n = ack_q; end
                else       e_recv_n = 1'b1;
                if (cmd_q[CB_STOP]) begin
                  state_n = ST_STOP; step_n = 2'd0; sda_n = 1'b0;
                end else begin
                  state_n = ST_IDLE; sda_n = 1'b1; e_over_n = 1'b1;
                end
              end
            end
          endcase
        end
      end
      default: begin
        if (tick) begin
          case (step_q)
            2'd0: begin step_n = 2'd1; scl_n = 1'b1; end
            2'd1: begin step_n = 2'd2; sda_n = 1'b1; e_end_n = 1'b1; end
            2'd2: step_n = 2'd3;
            default: begin state_n = ST_IDLE; e_over_n = 1'b1; end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; step_q <= 2'd0; bit_q <= '0; cmd_q <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1; ack_q <= 1'b0;
      ev_start <= 1'b0; ev_end <= 1'b0; ev_send <= 1'b0; ev_recv <= 1'b0;
      ev_ackerr <= 1'b0; ev_arblost <= 1'b0; ev_over <= 1'b0;
    end else begin
      state_q <= state_n; step_q <= step_n; bit_q <= bit_n; cmd_q <= cmd_n;
      scl_q <= scl_n; sda_q <= sda_n; ack_q <= ack_n;
      ev_start <= e_start_n; ev_end <= e_end_n; ev_send <= e_send_n;
      ev_recv <= e_recv_n; ev_ackerr <= e_ackerr_n; ev_arblost <= e_arb_n;
      ev_over <= e_over_n;
    end
  end

  assign scl_oe  = !scl_q;
  assign sda_oe  = !sda_q;
  assign rx_byte = sh_q;

  // R12: inside a byte, SDA holds while SCL stays high
  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYTE && $past(state_q) == ST_BYTE && scl_q && $past(scl_q))
      |-> $stable(sda_q));
  // R8: completion is only reported on return to idle
  p_over_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_over |-> (state_q == ST_IDLE));
  // R4: an acknowledge error always accompanies a sent byte
  p_ackerr_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ackerr |-> ev_send);
  // R9: arbitration loss leaves both lines released
  p_arb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arblost |-> (!scl_oe && !sda_oe && ev_over && !ev_send));
  // R11: a strobe during a running command leaves the latched command alone
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && cmd_valid) |=> $stable(cmd_q));
  // R7: STOP is reported with both lines high
  p_stop_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_cmd_engine_tb.sv
module i2c_cmd_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [4:0] cmd = 5'd0;
  logic [7:0] tx_byte = 8'd0;
  logic [15:0] hi_div = 16'd3, lo_div = 16'd5;
  logic scl_oe, sda_oe, busy;
  logic [7:0] rx_byte;
  logic ev_start, ev_end, ev_send, ev_recv, ev_ackerr, ev_arblost, ev_over;
  logic tgt_low = 1'b0, arb_force = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe | tgt_low | arb_force);

  always #5 clk = !clk;

  i2c_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .tx_byte(tx_byte),
    .scl_hi_div(hi_div), .scl_lo_div(lo_div), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_byte(rx_byte), .busy(busy),
    .ev_start(ev_start), .ev_end(ev_end), .ev_send(ev_send), .ev_recv(ev_recv),
    .ev_ackerr(ev_ackerr), .ev_arblost(ev_arblost), .ev_over(ev_over));

  int checks = 0, errors = 0, cycles = 0;
  int n_start = 0, n_end = 0, n_send = 0, n_recv = 0, n_ackerr = 0, n_arb = 0, n_over = 0;
  int b_start, b_end, b_send, b_recv, b_ackerr, b_arb, b_over, b_lstart, b_lstop;
  int n_lstart = 0, n_lstop = 0;
  int pos = -1, run_len = 0, last_hi = 0, last_lo = 0, lat = 0;
  logic first = 1'b0, tx_mode = 1'b0, quiet = 1'b1, tgt_ack_en = 1'b1, m_ack = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1, run_lvl = 1'b1;
  logic [7:0] got = 8'd0, last_got = 8'd0, rd_byte = 8'd0;

  always @(negedge clk) begin
    if (ev_start) n_start++;
    if (ev_end) n_end++;
    if (ev_send) n_send++;
    if (ev_recv) n_recv++;
    if (ev_ackerr) n_ackerr++;
    if (ev_arblost) n_arb++;
    if (ev_over) n_over++;
  end

  // SCL run-length meter and target device model
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_w == run_lvl) run_len++;
      else begin
        if (run_lvl) last_hi = run_len; else last_lo = run_len;
        run_lvl = scl_w; run_len = 1;
      end
      if (scl_w && scl_p && sda_p && !sda_w) begin
        n_lstart++; pos = -1; first = 1'b1; tx_mode = 1'b0; quiet = 1'b0; tgt_low = 1'b0;
      end else if (scl_w && scl_p && !sda_p && sda_w) begin
        n_lstop++; pos = -1; quiet = 1'b1; tgt_low = 1'b0;
      end else if (scl_w && !scl_p) begin
        if (!quiet && pos >= 0 && pos < 8 && !tx_mode) got = {got[6:0], sda_w};
        if (!quiet && pos == 8 && tx_mode) m_ack = sda_w;
      end else if (!scl_w && scl_p && !quiet) begin
        pos++;
        if (pos == 9) begin
          pos = 0;
          if (!tx_mode) last_got = got;
          if (first) tx_mode = got[0];
          else if (tx_mode && m_ack) quiet = 1'b1;
          first = 1'b0;
        end
        tgt_low = 1'b0;
        if (!quiet && pos == 8 && !tx_mode) tgt_low = tgt_ack_en;
        if (!quiet && pos >= 0 && pos < 8 && tx_mode) tgt_low = !rd_byte[7 - pos];
      end
    end
    scl_p = scl_w; sda_p = sda_w;
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      finish_sim();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic snap();
    b_start = n_start; b_end = n_end; b_send = n_send; b_recv = n_recv;
    b_ackerr = n_ackerr; b_arb = n_arb; b_over = n_over;
    b_lstart = n_lstart; b_lstop = n_lstop;
  endtask

  task automatic issue_cmd(input logic [4:0] c, input logic [7:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd = c; tx_byte = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_over();
    lat = 1;
    while (!ev_over && lat < 5000) begin @(negedge clk); lat++; end
    chk("R8", "command completed", int'(ev_over), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe", int'(scl_oe), 0);
    chk("R1", "sda_oe", int'(sda_oe), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "events", int'({ev_start, ev_end, ev_send, ev_recv, ev_ackerr, ev_arblost, ev_over}), 0);
  endtask

  task automatic t_empty();
    snap(); issue_cmd(5'h00, 8'h00); wait_over();
    chk("R8", "empty command latency", lat, 1);
    chk("R8", "one over pulse", n_over - b_over, 1);
    chk("R8", "no line activity", n_lstart - b_lstart, 0);
  endtask

  task automatic t_write_ack();
    snap(); issue_cmd(5'h0A, 8'hA4); wait_over();
    chk("R3", "start pulse", n_start - b_start, 1);
    chk("R3", "send pulse", n_send - b_send, 1);
    chk("R3", "byte seen by target", int'(last_got), 8'hA4);
    chk("R4", "no ack error when acked", n_ackerr - b_ackerr, 0);
    chk("R10", "busy after START", int'(busy), 1);
    chk("R13", "SCL held low", int'(scl_oe), 1);
    chk("R12", "one START on bus", n_lstart - b_lstart, 1);
    chk("R2", "high phase clocks", last_hi, 2 * (int'(hi_div) + 1));
    chk("R2", "low phase clocks", last_lo, 2 * (int'(lo_div) + 1));
  endtask

  task automatic t_ignore();
    snap();
    issue_cmd(5'h02, 8'h3C);
    repeat (20) @(negedge clk);
    issue_cmd(5'h01, 8'hFF);
    wait_over();
    repeat (40) @(negedge clk);
    chk("R11", "single over", n_over - b_over, 1);
    chk("R11", "no STOP from stray strobe", n_lstop - b_lstop, 0);
    chk("R11", "byte unchanged", int'(last_got), 8'h3C);
    chk("R11", "SCL still held", int'(scl_oe), 1);
  endtask

  task automatic t_stop();
    snap(); issue_cmd(5'h01, 8'h00); wait_over();
    chk("R7", "end pulse", n_end - b_end, 1);
    chk("R7", "STOP on bus", n_lstop - b_lstop, 1);
    chk("R7", "lines released", int'({scl_oe, sda_oe}), 0);
    chk("R10", "busy after STOP", int'(busy), 0);
    chk("R12", "no extra START", n_lstart - b_lstart, 0);
  endtask

  task automatic t_nack();
    snap(); tgt_ack_en = 1'b0;
    issue_cmd(5'h0B, 8'h9A); wait_over();
    tgt_ack_en = 1'b1;
    chk("R4", "ack error pulse", n_ackerr - b_ackerr, 1);
    chk("R4", "send pulse", n_send - b_send, 1);
    chk("R7", "end pulse", n_end - b_end, 1);
    chk("R10", "busy cleared", int'(busy), 0);
  endtask

  task automatic t_read();
    snap(); rd_byte = 8'hC3;
    issue_cmd(5'h0A, 8'hA5); wait_over();
    m_ack = 1'b1;
    issue_cmd(5'h04, 8'h00); wait_over();
    chk("R5", "received byte", int'(rx_byte), 8'hC3);
    chk("R5", "master ACK low", int'(m_ack), 0);
    chk("R5", "recv pulse", n_recv - b_recv, 1);
    rd_byte = 8'h9E; m_ack = 1'b0;
    issue_cmd(5'h15, 8'h00); wait_over();
    chk("R6", "received last byte", int'(rx_byte), 8'h9E);
    chk("R6", "master NACK released", int'(m_ack), 1);
    chk("R7", "end after read", n_end - b_end, 1);
    chk("R8", "three overs", n_over - b_over, 3);
  endtask

  task automatic t_arb();
    int w;
    snap();
    issue_cmd(5'h0A, 8'hFF);
    w = 0;
    while (!busy && w < 200) begin @(negedge clk); w++; end
    arb_force = 1'b1;
    wait_over();
    chk("R9", "arb pulse", n_arb - b_arb, 1);
    chk("R9", "no send", n_send - b_send, 0);
    chk("R9", "scl released", int'(scl_oe), 0);
    chk("R9", "sda released", int'(sda_oe), 0);
    arb_force = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "busy cleared by foreign STOP", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_empty();
    t_write_ack();
    t_ignore();
    t_stop();
    t_nack();
    t_read();
    t_arb();
    finish_sim();
  end
endmodule